// File: doc/BRIEF.md
# Page Write Staging Buffer with Row Wrap

This block sits between a serial-memory slave front end and an 8K x 8 storage array. It collects the data bytes of one page write, stages them in a 32-entry row buffer, and copies them into the array only when the bus master ends the transfer with STOP. The front end reports the start of a write with a strobe and the 13-bit target address. It then hands over each data byte with a one-cycle valid strobe and the level of the write-inhibit input. Finally it signals STOP with a strobe. The array is external and is reached through a simple one-cycle write port.

The row bits of the start address, bits 12 to 5, are frozen for the whole transfer. Only a 5-bit column counter moves. When the counter passes the end of the row it wraps to column 0 of the same row, so surplus bytes overwrite earlier positions. Every buffer entry carries a written flag. At commit the block walks the row one column per clock and writes only the flagged columns, so columns the master never touched keep their contents. A new START or repeated START before STOP throws the staged bytes away.

Top module: `pgwr_buffer`

## Requirements
- R1: After reset, busy, memWe and byteAck are low.
- R2: On pageStart the block latches startAddr[12:5] as the row and startAddr[4:0] as the starting column. Successive accepted bytes go to successive columns of that row.
- R3: After column 31 the column counter wraps to column 0 of the same row. The row never changes during a transfer.
- R4: A byte sent to a column that already holds a staged byte replaces it, and only the last value reaches the array.
- R5: A byte whose byteValid cycle has wrInhibit high is refused: byteAck stays low in that cycle, the byte is not staged, and the column still advances by one. An accepted byte raises byteAck combinationally in its byteValid cycle.
- R6: Nothing is written to the array before STOP. One cycle after a stopStrobe during an open transfer, busy rises and stays high for exactly 32 cycles.
- R7: While busy, the block visits columns 0 to 31 in ascending order, one per cycle. For each flagged column it pulses memWe with memAddr = {row, column} and memWdata = the staged byte. Unflagged columns produce no write.
- R8: A pageStart that arrives before STOP discards all staged bytes and opens a new transfer at the new address.
- R9: All written flags are cleared when a commit ends. A stopStrobe with no open transfer causes no busy and no write.
- R10: While busy, pageStart, byteValid and stopStrobe are ignored and byteAck stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pageStart | input | 1 | One-cycle strobe: a write transfer begins |
| startAddr | input | 13 | Target address captured with pageStart |
| byteValid | input | 1 | One-cycle strobe: a data byte is present |
| byteData | input | 8 | Data byte |
| wrInhibit | input | 1 | Write-inhibit level, sampled with byteValid |
| stopStrobe | input | 1 | One-cycle strobe: STOP seen on the bus |
| byteAck | output | 1 | High in a byteValid cycle whose byte is accepted |
| busy | output | 1 | Commit in progress |
| memWe | output | 1 | Array write enable |
| memAddr | output | 13 | Array write address |
| memWdata | output | 8 | Array write data |

## Verification
A short run from a mid-row column checks the plain mapping from start address to array address. A run that begins at column 30 separates a correct wrap inside the row from a row increment. A 34-byte run shows whether overwritten columns commit their last value rather than their first. Alternating inhibited and accepted bytes reveal whether refused bytes still move the column, and a restart before STOP tells a discard apart from a merge of the two transfers. Every array write is matched against a queue of predicted writes, so a write to an untouched column is also reported.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef struct packed {
    logic loadStart;
    logic store;
    logic skip;
    logic scanStep;
    logic clrAll;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_COMMIT
  } state_t;
endpackage

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  pageStart,
  input  logic  byteValid,
  input  logic  wrInhibit,
  input  logic  stopStrobe,
  input  logic  scanLast,
  output ctrl_t ctrl,
  output logic  busy,
  output logic  byteAck
);
  state_t state, nxtState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxtState;
  end

  always_comb begin
    ctrl     = '0;
    nxtState = state;
    case (state)
      ST_IDLE: begin
        if (pageStart) begin
          ctrl.loadStart = 1'b1;
          nxtState       = ST_FILL;
        end
      end
      ST_FILL: begin
        if (pageStart) begin
          ctrl.loadStart = 1'b1;
        end else if (stopStrobe) begin
          nxtState = ST_COMMIT;
        end else if (byteValid) begin
          if (wrInhibit) ctrl.skip  = 1'b1;
          else           ctrl.store = 1'b1;
        end
      end
      ST_COMMIT: begin
        ctrl.scanStep = 1'b1;
        if (scanLast) begin
          ctrl.clrAll = 1'b1;
          nxtState    = ST_IDLE;
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign busy    = (state == ST_COMMIT);
  assign byteAck = ctrl.store;

  // R6: STOP during an open transfer starts the commit on the next cycle
  a_r6_busy_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && stopStrobe && !pageStart) |=> busy);

  // R10: no byte is accepted while committing
  a_r10_no_ack_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !byteAck);

  // R5: at most one datapath action per cycle
  a_r5_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.loadStart, ctrl.store, ctrl.skip, ctrl.scanStep}));
endmodule

// File: rtl/pgwr_data.sv
module pgwr_data
  import pgwr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] byteData,
  output logic              scanLast,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int DEPTH = 1 << COL_W;

  logic [ROW_W-1:0]  rowBase;
  logic [COL_W-1:0]  col;
  logic [COL_W-1:0]  scanIdx;
  logic [DEPTH-1:0]  flags;
  logic [DATA_W-1:0] bufMem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowBase <= '0;
      col     <= '0;
    end else if (ctrl.loadStart) begin
      rowBase <= startAddr[ADDR_W-1:COL_W];
      col     <= startAddr[COL_W-1:0];
    end else if (ctrl.store || ctrl.skip) begin
      col <= col + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              scanIdx <= '0;
    else if (ctrl.scanStep) scanIdx <= scanIdx + 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flags[i]  <= 1'b0;
        bufMem[i] <= '0;
      end else if (ctrl.loadStart || ctrl.clrAll) begin
        flags[i] <= 1'b0;
      end else if (ctrl.store && col == COL_W'(i)) begin
        flags[i]  <= 1'b1;
        bufMem[i] <= byteData;
      end
    end
  end

  assign scanLast = (scanIdx == '1);
  assign memWe    = ctrl.scanStep && flags[scanIdx];
  assign memAddr  = {rowBase, scanIdx};
  assign memWdata = bufMem[scanIdx];

  // R3: the column wraps inside the row
  a_r3_col_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.store && col == '1) |=> (col == '0));

  // R3: the row is frozen while bytes arrive
  a_r3_row_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.store || ctrl.skip) |=> $stable(rowBase));

  // R9: the end of a commit leaves no flag set
  a_r9_flags_clear: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.clrAll |=> (flags == '0));
endmodule

// File: rtl/pgwr_buffer.sv
module pgwr_buffer
  import pgwr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int COL_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              wrInhibit,
  input  logic              stopStrobe,
  output logic              byteAck,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  ctrl_t ctrl;
  logic  scanLast;

  pgwr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pageStart  (pageStart),
    .byteValid  (byteValid),
    .wrInhibit  (wrInhibit),
    .stopStrobe (stopStrobe),
    .scanLast   (scanLast),
    .ctrl       (ctrl),
    .busy       (busy),
    .byteAck    (byteAck)
  );

  pgwr_data #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .startAddr (startAddr),
    .byteData  (byteData),
    .scanLast  (scanLast),
    .memWe     (memWe),
    .memAddr   (memAddr),
    .memWdata  (memWdata)
  );

  // R7: array writes happen only inside a commit
  a_r7_we_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);
endmodule

// File: tb/tb_pgwr_buffer.sv
module tb_pgwr_buffer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pageStart = 1'b0;
  logic [12:0] startAddr = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        wrInhibit = 1'b0;
  logic        stopStrobe = 1'b0;
  logic        byteAck, busy, memWe;
  logic [12:0] memAddr;
  logic [7:0]  memWdata;

  int testsRun = 0;
  int testsFailed = 0;
  int busyCnt = 0;
  bit finished = 1'b0;

  logic [7:0] bufM [32];
  bit         flagM [32];
  logic [7:0] rowM;
  logic [4:0] colM;
  logic [20:0] expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwr_buffer dut (
    .clk(clk), .rstN(rstN), .pageStart(pageStart), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .wrInhibit(wrInhibit),
    .stopStrobe(stopStrobe), .byteAck(byteAck), .busy(busy), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops predicted writes as the array port produces them (R7)
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) busyCnt++;
      if (memWe) begin
        if (expQ.size() == 0) begin
          check("R7 unexpected write", {11'd0, memAddr, memWdata}, 32'hFFFFFFFF);
        end else begin
          logic [20:0] e;
          e = expQ.pop_front();
          check("R7 write addr/data", {11'd0, memAddr, memWdata}, {11'd0, e});
        end
      end
    end
  end

  task automatic startPage(logic [12:0] a);
    @(posedge clk); #1;
    pageStart = 1'b1; startAddr = a;
    @(posedge clk); #1;
    pageStart = 1'b0;
    rowM = a[12:5]; colM = a[4:0];
    for (int i = 0; i < 32; i++) flagM[i] = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] d, bit inh, string req);
    @(posedge clk); #1;
    byteValid = 1'b1; byteData = d; wrInhibit = inh;
    @(negedge clk);
    check(req, byteAck, !inh);
    @(posedge clk); #1;
    byteValid = 1'b0; wrInhibit = 1'b0;
    if (!inh) begin
      bufM[colM] = d;
      flagM[colM] = 1'b1;
    end
    colM = colM + 1'b1;
  endtask

  task automatic stopPage();
    for (int i = 0; i < 32; i++)
      if (flagM[i]) expQ.push_back({rowM, 5'(i), bufM[i]});
    for (int i = 0; i < 32; i++) flagM[i] = 1'b0;
    @(posedge clk); #1;
    stopStrobe = 1'b1;
    @(negedge clk);
    check("R6 no busy in stop cycle", busy, 1'b0);
    busyCnt = 0;
    @(posedge clk); #1;
    stopStrobe = 1'b0;
    @(negedge clk);
    check("R6 busy after stop", busy, 1'b1);
    while (busy) @(negedge clk);
    check("R6 busy length", busyCnt, 32);
    check("R7 all writes seen", expQ.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R1 busy reset", busy, 1'b0);
    check("R1 memWe reset", memWe, 1'b0);
    check("R1 byteAck reset", byteAck, 1'b0);
    rstN = 1'b1;

    // R2: plain run from row 9 column 3
    startPage(13'h0123);
    for (int i = 0; i < 4; i++) sendByte(8'hA0 + 8'(i), 1'b0, "R2 ack");
    stopPage();

    // R3: wrap from column 30 inside row 0x7F
    startPage({8'h7F, 5'd30});
    for (int i = 0; i < 5; i++) sendByte(8'h30 + 8'(i), 1'b0, "R3 ack");
    stopPage();

    // R4: 34 bytes, columns 0 and 1 overwritten
    startPage({8'h15, 5'd0});
    for (int i = 0; i < 34; i++) sendByte(8'h40 + 8'(i), 1'b0, "R4 ack");
    stopPage();

    // R5: inhibited bytes refused but advance the column
    startPage({8'h22, 5'd10});
    for (int i = 0; i < 6; i++) sendByte(8'h60 + 8'(i), bit'(i % 2), "R5 ack");
    stopPage();

    // R8: restart before STOP discards staged bytes
    startPage({8'h33, 5'd4});
    for (int i = 0; i < 3; i++) sendByte(8'h70 + 8'(i), 1'b0, "R8 ack");
    startPage({8'h44, 5'd20});
    sendByte(8'h99, 1'b0, "R8 ack");
    stopPage();

    // R9: STOP with no open transfer does nothing
    @(posedge clk); #1; stopStrobe = 1'b1;
    @(posedge clk); #1; stopStrobe = 1'b0;
    @(negedge clk);
    check("R9 idle stop no busy", busy, 1'b0);

    // R10: inputs ignored during commit
    startPage({8'h50, 5'd1});
    sendByte(8'h11, 1'b0, "R10 setup ack");
    for (int i = 0; i < 32; i++) if (flagM[i]) expQ.push_back({rowM, 5'(i), bufM[i]});
    for (int i = 0; i < 32; i++) flagM[i] = 1'b0;
    @(posedge clk); #1; stopStrobe = 1'b1;
    @(posedge clk); #1; stopStrobe = 1'b0;
    @(posedge clk); #1; byteValid = 1'b1; byteData = 8'hEE;
    @(negedge clk);
    check("R10 no ack while busy", byteAck, 1'b0);
    @(posedge clk); #1; byteValid = 1'b0; pageStart = 1'b1; startAddr = 13'h1FFF;
    @(posedge clk); #1; pageStart = 1'b0;
    while (busy) @(negedge clk);
    check("R10 writes complete", expQ.size(), 0);
    @(posedge clk); #1; stopStrobe = 1'b1;
    @(posedge clk); #1; stopStrobe = 1'b0;
    @(negedge clk);
    check("R10 ignored start left idle", busy, 1'b0);
    repeat (3) @(negedge clk);
    check("R9 no stray writes", expQ.size(), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule